// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the active-low system reset for a processor. It takes digitized status flags: a supply-below-threshold flag, an active-low manual reset button, an auxiliary reset-request flag, a watchdog kick input and a battery-backup flag. Reset is asserted while any of these causes is present. It stays asserted for a programmable number of clock cycles after the last cause goes away, so downstream logic always sees a reset pulse of at least that length.

An internal watchdog expects its input to change level regularly. If the level holds for longer than the watchdog timeout, the watchdog starts one reset pulse of the standard length. The watchdog is held cleared while reset is asserted. A stuck input therefore produces a regular train of reset pulses. Every input passes through a multi-stage synchronizer. The manual reset input also goes through a low-level glitch filter, so no external debounce is needed. All time bases are parameters in clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While the supply-low flag is 1, `rst_n_o` is 0. After the flag rises, `rst_n_o` falls on the third rising clock edge.
- R2: A low level on `mr_n_i` that lasts `GLITCH_CYCLES - 1` cycles has no effect on `rst_n_o`. A low level of `GLITCH_CYCLES` cycles or longer causes a reset. `rst_n_o` falls `GLITCH_CYCLES + 3` edges after the input falls.
- R3: While `aux_low_i` is 1, `rst_n_o` is 0. It falls on the third edge after `aux_low_i` rises.
- R4: When the last cause is removed, `rst_n_o` stays 0 for a further `RST_CYCLES` cycles. It rises on the `RST_CYCLES + 2`-th edge after the input that removed the cause changes.
- R5: While `por_n` is 0, `rst_n_o` is 0. After `por_n` is released with no cause present, `rst_n_o` rises on the `RST_CYCLES`-th edge.
- R6: A watchdog input that changes level at least once every `WD_CYCLES` cycles never causes a reset.
- R7: If the watchdog input holds one level, `rst_n_o` falls `WD_CYCLES + 1` edges after reset was last released. It then stays 0 for exactly `RST_CYCLES` cycles.
- R8: The watchdog count is held at zero while reset is asserted. With a stuck input, the next watchdog reset therefore again comes `WD_CYCLES + 1` edges after each release.
- R9: While `backup_i` is 1, `rst_n_o` is 0, and manual-reset, auxiliary and watchdog activity during backup has no effect on the release. `rst_n_o` rises `RST_CYCLES + 2` edges after `backup_i` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | 1 = supply below its threshold (asynchronous) |
| mr_n_i | input | 1 | Manual reset request, active low (asynchronous, bouncy) |
| aux_low_i | input | 1 | 1 = auxiliary reset request active (asynchronous) |
| wdi_i | input | 1 | Watchdog kick; any level change restarts the watchdog |
| backup_i | input | 1 | 1 = battery-backup mode, forces reset |
| rst_n_o | output | 1 | System reset, active low |

## Verification
Directed sequences drive each cause on its own and measure the exact edge on which reset falls and rises. This separates synchronizer latency from the stretch count. Manual-reset pulses one cycle shorter than the filter width and exactly at the filter width show where the glitch filter draws its line. A stuck watchdog input is timed through two full pulse periods, which shows both the fixed pulse length and that the count is cleared during reset. A regularly toggled input shows that kicks are honoured. A long seeded random phase mixes overlapping causes, backup spells and watchdog stalls. It compares every cycle against a reference model built from the requirements, which exposes interactions that no single directed pattern reaches.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   // bits needed to hold the value n (at least one)
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic por_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $fatal(1, "rsv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pipe_q <= {STAGES{RST_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rsv_glitch.sv
module rsv_glitch
   import rsv_pkg::*;
#(
   parameter int unsigned FILT = 4
) (
   input  logic clk,
   input  logic por_n,
   input  logic lvl_n_i,
   output logic act_o
);
   generate
      if (FILT == 0) begin : g_bypass
         assign act_o = ~lvl_n_i;
      end else begin : g_filter
         localparam int unsigned W = cnt_w(FILT);
         localparam logic [W-1:0] TOP = W'(FILT);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)          cnt_q <= '0;
            else if (lvl_n_i)    cnt_q <= '0;
            else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
         end

         assign act_o = (cnt_q == TOP);

         assert_high_clears_R2: assert property (@(posedge clk) disable iff (!por_n)
            lvl_n_i |=> !act_o);
      end
   endgenerate
endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog
   import rsv_pkg::*;
#(
   parameter int unsigned WD_CYCLES = 40
) (
   input  logic clk,
   input  logic por_n,
   input  logic wd_s_i,
   input  logic hold_i,
   output logic fire_o
);
   initial begin
      if (WD_CYCLES < 2) $fatal(1, "rsv_watchdog: WD_CYCLES must be at least 2");
   end

   localparam int unsigned W = cnt_w(WD_CYCLES - 1);
   localparam logic [W-1:0] LAST = W'(WD_CYCLES - 1);

   logic [W-1:0] cnt_q;
   logic         prev_q;
   logic         fire_q;
   logic         kick;

   assign kick = wd_s_i ^ prev_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
         fire_q <= 1'b0;
      end else begin
         prev_q <= wd_s_i;
         fire_q <= 1'b0;
         if (hold_i || kick) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            fire_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign fire_o = fire_q;

   assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!por_n)
      fire_o |=> !fire_o);
   assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!por_n)
      hold_i |=> (cnt_q == '0) && !fire_o);
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
   import rsv_pkg::*;
#(
   parameter int unsigned RST_CYCLES = 24
) (
   input  logic clk,
   input  logic por_n,
   input  logic cause_i,
   output logic rst_n_o
);
   initial begin
      if (RST_CYCLES < 1) $fatal(1, "rsv_stretch: RST_CYCLES must be at least 1");
   end

   localparam int unsigned W = cnt_w(RST_CYCLES);
   localparam logic [W-1:0] LOAD = W'(RST_CYCLES);

   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)             left_q <= LOAD;
      else if (cause_i)       left_q <= LOAD;
      else if (left_q != '0)  left_q <= left_q - 1'b1;
   end

   assign rst_n_o = (left_q == '0);

   assert_cause_asserts_R1: assert property (@(posedge clk) disable iff (!por_n)
      cause_i |=> !rst_n_o);
   assert_release_quiet_R4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_n_o) |-> !$past(cause_i));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned RST_CYCLES    = 24,
   parameter int unsigned WD_CYCLES     = 40,
   parameter int unsigned GLITCH_CYCLES = 4,
   parameter bit          WDOG_EN       = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic supply_low_i,
   input  logic mr_n_i,
   input  logic aux_low_i,
   input  logic wdi_i,
   input  logic backup_i,
   output logic rst_n_o
);
   logic sup_s, mr_n_s, aux_s, wd_s, bk_s;
   logic mr_act, wd_fire, cause;

   rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
      .clk(clk), .por_n(por_n), .d_i(supply_low_i), .q_o(sup_s));
   rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_mr (
      .clk(clk), .por_n(por_n), .d_i(mr_n_i), .q_o(mr_n_s));
   rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_aux (
      .clk(clk), .por_n(por_n), .d_i(aux_low_i), .q_o(aux_s));
   rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_wd (
      .clk(clk), .por_n(por_n), .d_i(wdi_i), .q_o(wd_s));
   rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_bk (
      .clk(clk), .por_n(por_n), .d_i(backup_i), .q_o(bk_s));

   rsv_glitch #(.FILT(GLITCH_CYCLES)) u_glitch (
      .clk(clk), .por_n(por_n), .lvl_n_i(mr_n_s), .act_o(mr_act));

   generate
      if (WDOG_EN) begin : g_wdog
         rsv_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
            .clk(clk), .por_n(por_n), .wd_s_i(wd_s),
            .hold_i(~rst_n_o), .fire_o(wd_fire));
      end else begin : g_no_wdog
         logic unused_wd;
         assign unused_wd = wd_s;
         assign wd_fire   = 1'b0;
      end
   endgenerate

   // backup forces reset and masks the user-side causes
   assign cause = sup_s | bk_s | wd_fire | (~bk_s & (aux_s | mr_act));

   rsv_stretch #(.RST_CYCLES(RST_CYCLES)) u_stretch (
      .clk(clk), .por_n(por_n), .cause_i(cause), .rst_n_o(rst_n_o));

   assert_backup_forces_R9: assert property (@(posedge clk) disable iff (!por_n)
      bk_s |=> !rst_n_o);
   assert_aux_forces_R3: assert property (@(posedge clk) disable iff (!por_n)
      (aux_s && !bk_s) |=> !rst_n_o);
endmodule

// File: tb/rst_supervisor_bench.sv
module rst_supervisor_bench;
   localparam int RST = 24;
   localparam int WD  = 40;
   localparam int G   = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic supply_low = 1'b0, mr_n = 1'b1, aux_low = 1'b0, wdi = 1'b0, backup = 1'b0;
   logic wd_auto = 1'b1;
   logic rst_n_o;
   int   n_cmp = 0, n_err = 0;
   bit   done = 1'b0;

   always #5ns clk = ~clk;

   rst_supervisor #(.RST_CYCLES(RST), .WD_CYCLES(WD), .GLITCH_CYCLES(G)) u_rst_supervisor (
      .clk(clk), .por_n(por_n), .supply_low_i(supply_low), .mr_n_i(mr_n),
      .aux_low_i(aux_low), .wdi_i(wdi), .backup_i(backup), .rst_n_o(rst_n_o));

   // watchdog kicker: toggles every 8 cycles while enabled
   int kick_cnt = 0;
   always @(negedge clk) begin
      if (wd_auto) begin
         kick_cnt = kick_cnt + 1;
         if (kick_cnt >= 8) begin kick_cnt = 0; wdi <= ~wdi; end
      end else kick_cnt = 0;
   end

   // reference model derived from the requirement timing
   logic [1:0] p_sup, p_mr, p_aux, p_wd, p_bk;
   int m_mr, m_wd, m_left;
   bit m_prev, m_fire;
   function automatic bit model_cause(bit sup, bit bk, bit aux, bit mract, bit fire);
      return sup | bk | fire | (!bk & (aux | mract));
   endfunction
   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         p_sup = '0; p_mr = '1; p_aux = '0; p_wd = '0; p_bk = '0;
         m_mr = 0; m_wd = 0; m_left = RST; m_prev = 0; m_fire = 0;
      end else begin
         bit c, hold, kick;
         c    = model_cause(p_sup[1], p_bk[1], p_aux[1], m_mr == G, m_fire);
         hold = (m_left != 0);
         kick = (p_wd[1] != m_prev);
         m_prev = p_wd[1];
         if (hold || kick) begin m_wd = 0; m_fire = 0; end
         else if (m_wd == WD - 1) begin m_wd = 0; m_fire = 1; end
         else begin m_wd = m_wd + 1; m_fire = 0; end
         if (p_mr[1]) m_mr = 0; else if (m_mr != G) m_mr = m_mr + 1;
         if (c) m_left = RST; else if (m_left != 0) m_left = m_left - 1;
         p_sup = {p_sup[0], supply_low}; p_mr = {p_mr[0], mr_n};
         p_aux = {p_aux[0], aux_low};    p_wd = {p_wd[0], wdi};
         p_bk  = {p_bk[0], backup};
      end
   end

   always @(negedge clk) begin
      if (por_n) begin
         n_cmp++;
         if (rst_n_o !== (m_left == 0)) begin
            n_err++;
            $display("FAIL R4 model cycle: actual=%0b expected=%0b", rst_n_o, m_left == 0);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL run timeout (all requirements): actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R5: power-on
      tick(3);
      check("R5 held in por", rst_n_o, 1'b0);
      por_n = 1'b1;
      tick(RST - 1); check("R5 still low", rst_n_o, 1'b0);
      tick(1);       check("R5 released", rst_n_o, 1'b1);

      // R1 / R4: supply
      supply_low = 1'b1;
      tick(2); check("R1 latency high", rst_n_o, 1'b1);
      tick(1); check("R1 asserted", rst_n_o, 1'b0);
      tick(10); check("R1 held", rst_n_o, 1'b0);
      supply_low = 1'b0;
      tick(RST + 1); check("R4 stretch low", rst_n_o, 1'b0);
      tick(1);       check("R4 release", rst_n_o, 1'b1);

      // R3: auxiliary
      aux_low = 1'b1;
      tick(2); check("R3 latency high", rst_n_o, 1'b1);
      tick(1); check("R3 asserted", rst_n_o, 1'b0);
      tick(6);
      aux_low = 1'b0;
      tick(RST + 1); check("R3 stretch low", rst_n_o, 1'b0);
      tick(1);       check("R3 release", rst_n_o, 1'b1);

      // R2: glitch filter
      mr_n = 1'b0; tick(G - 1); mr_n = 1'b1;
      for (int i = 0; i < 12; i++) begin tick(1); check("R2 short pulse ignored", rst_n_o, 1'b1); end
      mr_n = 1'b0; tick(G); mr_n = 1'b1;
      tick(2); check("R2 before filter output", rst_n_o, 1'b1);
      tick(1); check("R2 pulse honoured", rst_n_o, 1'b0);
      tick(RST + 5); check("R2 released", rst_n_o, 1'b1);

      // R7 / R8: stuck watchdog
      wd_auto = 1'b0;
      supply_low = 1'b1; tick(12); supply_low = 1'b0;
      tick(RST + 2); check("R4 release before stall", rst_n_o, 1'b1);
      tick(WD);      check("R7 before timeout", rst_n_o, 1'b1);
      tick(1);       check("R7 watchdog reset", rst_n_o, 1'b0);
      tick(RST - 1); check("R7 pulse length low", rst_n_o, 1'b0);
      tick(1);       check("R7 pulse ends", rst_n_o, 1'b1);
      tick(WD);      check("R8 restart after release", rst_n_o, 1'b1);
      tick(1);       check("R8 recurring pulse", rst_n_o, 1'b0);

      // R6: kicked watchdog
      wd_auto = 1'b1;
      tick(RST + 2);
      for (int i = 0; i < 3 * WD; i++) begin tick(1); check("R6 kicked stays high", rst_n_o, 1'b1); end

      // R9: backup
      wd_auto = 1'b0;
      backup = 1'b1;
      tick(2); check("R9 latency high", rst_n_o, 1'b1);
      tick(1); check("R9 asserted", rst_n_o, 1'b0);
      mr_n = 1'b0; aux_low = 1'b1; tick(20);
      mr_n = 1'b1; aux_low = 1'b0; tick(10);
      backup = 1'b0; wd_auto = 1'b1;
      tick(RST + 1); check("R9 stretch low", rst_n_o, 1'b0);
      tick(1);       check("R9 release", rst_n_o, 1'b1);

      // random phase, checked by the model every cycle
      begin
         int mr_len = 0;
         for (int i = 0; i < 6000; i++) begin
            tick(1);
            if ($urandom % 1000 < 8) supply_low = ~supply_low;
            if ($urandom % 1000 < 6) aux_low = ~aux_low;
            if ($urandom % 1000 < 3) backup = ~backup;
            if ($urandom % 1000 < 8) wd_auto = ~wd_auto;
            if (mr_n) begin
               if ($urandom % 100 < 2) begin mr_n = 1'b0; mr_len = 1 + int'($urandom % 8); end
            end else begin
               mr_len--;
               if (mr_len <= 0) mr_n = 1'b1;
            end
         end
      end
      supply_low = 1'b0; aux_low = 1'b0; backup = 1'b0; mr_n = 1'b1; wd_auto = 1'b1;
      tick(RST + 20);
      check("R4 idle after random", rst_n_o, 1'b1);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule